// File: doc/BRIEF.md
# Burst DMA Request Generator

This block is a 32-word write buffer that sits between a register-bus slave port and a downstream consumer. It tells a system DMA engine when to move data by raising a request. The request is raised whenever the buffer has enough free entries to take a whole burst. Software picks the burst length (4, 8 or 16 words of 32 bits) with a select input. The request follows the free-space level on every cycle.

A control bit turns the request off. With the request off, the burst select has no effect. The buffer then works as a plain memory-mapped write target: the CPU writes into it directly, and a write to a full buffer stalls with the bus-ready handshake low until the consumer frees an entry. The consumer drains words in order through a show-ahead read port.

Top module: `burst_dma_req`

## Requirements
- R1: After reset the buffer is empty: `empty_o`=1, `full_o`=0, `free_o`=32, `rd_valid_o`=0, `wr_ready_o`=1. `dma_req_o`=1 when requests are enabled.
- R2: `burst_sel_i` encodes the burst length: 0 gives 4 words, 1 gives 8 words, 2 gives 16 words, and the reserved value 3 is treated as 16 words.
- R3: With `req_dis_i`=0, `dma_req_o` is high exactly when `free_o` is at least the selected burst length. It follows the current level in the same cycle that the level changes.
- R4: With `req_dis_i`=1, `dma_req_o` stays low for every level and every burst select. Writes are still accepted as plain CPU writes.
- R5: While the buffer is full, `wr_ready_o` is low and a pending write is not stored. The write completes in the first cycle after a drain frees an entry, and no word is lost or duplicated.
- R6: Words leave in write order. `rd_data_o` shows the oldest word whenever `rd_valid_o` is high, and `rd_valid_o` equals `!empty_o`.
- R7: When a write and a drain are accepted in the same cycle, `free_o` does not change.
- R8: `free_o` equals 32 minus the number of stored words. `full_o` is high at 0 free entries and `empty_o` is high at 32 free entries.
- R9: A drain request while the buffer is empty has no effect: `free_o` stays 32 and later data is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| burst_sel_i | input | 2 | Burst length select (0:4, 1:8, 2:16, 3:16) |
| req_dis_i | input | 1 | 1 disables the DMA request |
| wr_valid_i | input | 1 | Bus write pending |
| wr_data_i | input | 32 | Bus write data |
| wr_ready_o | output | 1 | Write accepted this cycle when high together with wr_valid_i |
| rd_en_i | input | 1 | Consumer drain request |
| rd_valid_o | output | 1 | Buffer holds at least one word |
| rd_data_o | output | 32 | Oldest stored word |
| dma_req_o | output | 1 | DMA burst request |
| free_o | output | 6 | Free entries |
| full_o | output | 1 | No free entry |
| empty_o | output | 1 | No stored word |

## Verification
A miscounted level shows up right away on `free_o`. In the same cycle it also makes `dma_req_o` wrong at one of the three burst thresholds. A slip between the pointers and the level surfaces later: when the buffer is drained, words come out of order, duplicated or missing, so every test ends with a full drain and an ordered comparison. A wrong stall decision is caught at the full boundary within one cycle, either as `wr_ready_o` high at zero free entries or as a held write that never completes.

// File: rtl/burst_req_pkg.sv
package burst_req_pkg;

  typedef enum logic [1:0] {
    BURST_4   = 2'd0,
    BURST_8   = 2'd1,
    BURST_16  = 2'd2,
    BURST_RSV = 2'd3
  } burst_sel_e;

  // reserved encoding falls back to the longest burst
  function automatic int unsigned burst_words(burst_sel_e sel);
    case (sel)
      BURST_4:  return 4;
      BURST_8:  return 8;
      default:  return 16;
    endcase
  endfunction

endpackage

// File: rtl/brq_fifo_mem.sv
module brq_fifo_mem #(
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     wptr_q, rptr_q;

  function automatic logic [AW-1:0] ptr_next(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      if (push_i) wptr_q <= ptr_next(wptr_q);
      if (pop_i)  rptr_q <= ptr_next(rptr_q);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wptr_q] <= wdata_i;
  end

  assign rdata_o = mem_q[rptr_q];

endmodule

// File: rtl/brq_level.sv
module brq_level #(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  output logic [CNT_W-1:0] free_o,
  output logic             full_o,
  output logic             empty_o
);

  logic [CNT_W-1:0] used_q;

  // push and pop in one cycle cancel out
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      used_q <= '0;
    end else begin
      case ({push_i, pop_i})
        2'b10:   used_q <= used_q + CNT_W'(1);
        2'b01:   used_q <= used_q - CNT_W'(1);
        default: used_q <= used_q;
      endcase
    end
  end

  assign free_o  = CNT_W'(DEPTH) - used_q;
  assign full_o  = (used_q == CNT_W'(DEPTH));
  assign empty_o = (used_q == '0);

endmodule

// File: rtl/brq_req_gen.sv
module brq_req_gen
  import burst_req_pkg::*;
#(
  parameter int unsigned CNT_W = 6
) (
  input  burst_sel_e       sel_i,
  input  logic             dis_i,
  input  logic [CNT_W-1:0] free_i,
  output logic             req_o
);

  logic [CNT_W-1:0] thr;

  assign thr   = CNT_W'(burst_words(sel_i));
  assign req_o = !dis_i && (free_i >= thr);

endmodule

// File: rtl/burst_dma_req.sv
module burst_dma_req
  import burst_req_pkg::*;
#(
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        burst_sel_i,
  input  logic              req_dis_i,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              wr_ready_o,
  input  logic              rd_en_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              dma_req_o,
  output logic [CNT_W-1:0]  free_o,
  output logic              full_o,
  output logic              empty_o
);

  logic push, pop;
  logic full, empty;

  // a write to a full buffer waits; ready reopens the cycle after a drain
  assign wr_ready_o = !full;
  assign push       = wr_valid_i && !full;
  assign pop        = rd_en_i && !empty;
  assign rd_valid_o = !empty;
  assign full_o     = full;
  assign empty_o    = empty;

  brq_fifo_mem #(.DEPTH(DEPTH), .DATA_W(DATA_W)) i_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .pop_i   (pop),
    .wdata_i (wr_data_i),
    .rdata_o (rd_data_o)
  );

  brq_level #(.DEPTH(DEPTH)) i_level (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .pop_i   (pop),
    .free_o  (free_o),
    .full_o  (full),
    .empty_o (empty)
  );

  brq_req_gen #(.CNT_W(CNT_W)) i_req (
    .sel_i  (burst_sel_e'(burst_sel_i)),
    .dis_i  (req_dis_i),
    .free_i (free_o),
    .req_o  (dma_req_o)
  );

endmodule

// File: rtl/brq_checker.sv
module brq_checker
  import burst_req_pkg::*;
#(
  parameter int unsigned DEPTH  = 32,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       burst_sel_i,
  input logic             req_dis_i,
  input logic             wr_valid_i,
  input logic             wr_ready_o,
  input logic             rd_en_i,
  input logic             rd_valid_o,
  input logic             dma_req_o,
  input logic [CNT_W-1:0] free_o,
  input logic             full_o,
  input logic             empty_o
);

  logic             acc_wr, acc_rd;
  logic [CNT_W-1:0] need;

  assign acc_wr = wr_valid_i && wr_ready_o;
  assign acc_rd = rd_en_i && rd_valid_o;
  assign need   = CNT_W'(burst_words(burst_sel_e'(burst_sel_i)));

  p_req_room_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o |-> (free_o >= need));

  p_dis_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_dis_i |-> !dma_req_o);

  p_no_overflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !wr_ready_o);

  p_valid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o == !empty_o);

  p_both_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_wr && acc_rd) |=> $stable(free_o));

  p_push_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_wr && !acc_rd) |=> (free_o == $past(free_o) - CNT_W'(1)));

  p_pop_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_rd && !acc_wr) |=> (free_o == $past(free_o) + CNT_W'(1)));

  p_empty_drain_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && !acc_wr) |=> empty_o);

endmodule

bind burst_dma_req brq_checker #(.DEPTH(DEPTH)) i_brq_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .burst_sel_i (burst_sel_i),
  .req_dis_i   (req_dis_i),
  .wr_valid_i  (wr_valid_i),
  .wr_ready_o  (wr_ready_o),
  .rd_en_i     (rd_en_i),
  .rd_valid_o  (rd_valid_o),
  .dma_req_o   (dma_req_o),
  .free_o      (free_o),
  .full_o      (full_o),
  .empty_o     (empty_o)
);

// File: tb/test_burst_dma_req.sv
`timescale 1ns/1ps
module test_burst_dma_req;

  localparam int DEPTH = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  burst_sel = 2'd2;
  logic        req_dis = 1'b0;
  logic        wr_valid = 1'b0;
  logic [31:0] wr_data = '0;
  logic        wr_ready;
  logic        rd_en = 1'b0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        dma_req;
  logic [5:0]  free;
  logic        full, empty;

  int checks = 0;
  int fails  = 0;
  logic [31:0] model_q[$];

  always #4 clk = ~clk;

  burst_dma_req i_burst_dma_req (
    .clk_i(clk), .rst_ni(rst_n), .burst_sel_i(burst_sel), .req_dis_i(req_dis),
    .wr_valid_i(wr_valid), .wr_data_i(wr_data), .wr_ready_o(wr_ready),
    .rd_en_i(rd_en), .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .dma_req_o(dma_req), .free_o(free), .full_o(full), .empty_o(empty)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int blen(input logic [1:0] s);
    return (s == 2'd0) ? 4 : (s == 2'd1) ? 8 : 16;
  endfunction

  task automatic idle();
    @(negedge clk);
    wr_valid = 1'b0;
    rd_en    = 1'b0;
    #1;
  endtask

  // push one word, waiting out any stall
  task automatic push_word(input logic [31:0] d);
    @(negedge clk);
    rd_en    = 1'b0;
    wr_valid = 1'b1;
    wr_data  = d;
    #1;
    while (!wr_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    model_q.push_back(d);
  endtask

  // pop one word and compare with the model
  task automatic pop_check(input string req);
    logic [31:0] exp;
    @(negedge clk);
    wr_valid = 1'b0;
    rd_en    = 1'b1;
    #1;
    exp = model_q.pop_front();
    chk(rd_valid, req, {31'd0, rd_valid}, 32'd1);
    chk(rd_data == exp, req, rd_data, exp);
    @(posedge clk);
  endtask

  task automatic drain_all(input string req);
    while (model_q.size() > 0) pop_check(req);
    idle();
    chk(empty && free == 6'd32, req, {26'd0, free}, 32'd32);
  endtask

  task automatic check_level(input int n);
    chk(free == 6'(DEPTH - n), "R8 free", {26'd0, free}, 32'(DEPTH - n));
    chk(full == (n == DEPTH), "R8 full", {31'd0, full}, {31'd0, n == DEPTH});
    chk(empty == (n == 0), "R8 empty", {31'd0, empty}, {31'd0, n == 0});
    chk(rd_valid == (n != 0), "R6 valid", {31'd0, rd_valid}, {31'd0, n != 0});
  endtask

  task automatic t_reset();
    #1;
    chk(empty && !full && !rd_valid && wr_ready, "R1 flags", {28'd0, empty, full, rd_valid, wr_ready}, 32'b1001);
    chk(free == 6'd32, "R1 free", {26'd0, free}, 32'd32);
    chk(dma_req, "R1 req", {31'd0, dma_req}, 32'd1);
  endtask

  // R2 R3 R4: sweep every level, every select, both disable values
  task automatic t_thresholds();
    for (int n = 0; n <= DEPTH; n++) begin
      if (n > 0) begin
        push_word(32'hA000_0000 + 32'(n));
        idle();
      end
      check_level(n);
      for (int s = 0; s < 4; s++) begin
        for (int d = 0; d < 2; d++) begin
          burst_sel = 2'(s);
          req_dis   = d[0];
          #1;
          if (d == 1)
            chk(!dma_req, "R4 disabled", {31'd0, dma_req}, 32'd0);
          else
            chk(dma_req == ((DEPTH - n) >= blen(2'(s))), "R2 R3 threshold",
                {31'd0, dma_req}, {31'd0, (DEPTH - n) >= blen(2'(s))});
        end
      end
      burst_sel = 2'd2;
      req_dis   = 1'b0;
    end
    drain_all("R6 order after sweep");
  endtask

  // R5: held write while full completes after one drain, nothing lost
  task automatic t_full_stall();
    logic [31:0] first;
    req_dis = 1'b1;
    for (int i = 0; i < DEPTH; i++) push_word(32'hB000_0000 + 32'(i));
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = 32'hDEAD_BEEF;
    #1;
    for (int k = 0; k < 3; k++) begin
      chk(!wr_ready && full, "R5 stall", {31'd0, wr_ready}, 32'd0);
      chk(free == 6'd0, "R5 not stored", {26'd0, free}, 32'd0);
      @(negedge clk);
      #1;
    end
    rd_en = 1'b1;
    first = model_q.pop_front();
    chk(rd_data == first, "R5 head", rd_data, first);
    @(negedge clk);
    rd_en = 1'b0;
    #1;
    chk(wr_ready && free == 6'd1, "R5 reopen", {26'd0, free}, 32'd1);
    @(posedge clk);
    model_q.push_back(32'hDEAD_BEEF);
    @(negedge clk);
    wr_valid = 1'b0;
    #1;
    chk(full && free == 6'd0, "R5 completed once", {26'd0, free}, 32'd0);
    req_dis = 1'b0;
    drain_all("R5 R6 order after stall");
  endtask

  // R7: simultaneous write and drain hold the level
  task automatic t_simul();
    for (int i = 0; i < 5; i++) push_word(32'hC000_0000 + 32'(i));
    idle();
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      wr_valid = 1'b1;
      rd_en    = 1'b1;
      wr_data  = 32'hC100_0000 + 32'(k);
      #1;
      chk(rd_data == model_q[0], "R7 head", rd_data, model_q[0]);
      chk(free == 6'd27, "R7 free stable", {26'd0, free}, 32'd27);
      @(posedge clk);
      void'(model_q.pop_front());
      model_q.push_back(32'hC100_0000 + 32'(k));
    end
    idle();
    chk(free == 6'd27, "R7 free after", {26'd0, free}, 32'd27);
    drain_all("R7 order");
  endtask

  // R9: drain on empty is ignored
  task automatic t_empty_drain();
    @(negedge clk);
    rd_en = 1'b1;
    repeat (3) @(negedge clk);
    rd_en = 1'b0;
    #1;
    chk(free == 6'd32 && empty, "R9 free", {26'd0, free}, 32'd32);
    push_word(32'hE000_0001);
    push_word(32'hE000_0002);
    idle();
    chk(free == 6'd30, "R9 level", {26'd0, free}, 32'd30);
    drain_all("R9 data");
  endtask

  bit done = 1'b0;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_thresholds();
    t_full_stall();
    t_simul();
    t_empty_drain();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule